// File: doc/BRIEF.md
# Four-Tap Signed Multiply-Sum Datapath

This block is a pipelined four-tap multiply-accumulate datapath for filtering and interpolating pixels. It has four 10-bit two's-complement data lanes. Each lane has its own data register with an active-low load strobe. Each lane's data is multiplied by an 11-bit two's-complement weight that is presented alongside it. The four products are added at full precision, and a 16-bit window of that sum is registered at the output. A bilinear interpolation of a 2x2 pixel kernel, or one section of a wider FIR, fits directly onto the four lanes.

A single format input selects how the operands are read. In fractional mode the data carries nine fraction bits, the weights carry nine fraction bits with two integer bits, and the output keeps nine fraction bits by dropping the low nine bits of the sum. In integer mode every operand is a plain integer and the output is the low sixteen bits of the sum. The format bit moves down the pipeline with the data it describes, so the mode may change on any cycle.

The datapath has three register stages: input capture, product, and output window. The two architectural states are RESET, where every stage holds zero, and RUN. The design moves from RESET to RUN when reset is released and returns from RUN to RESET when reset is asserted.

Top module: `quad_mac_filter`

## Requirements
- R1: While reset is low, every pipeline register is zero, so `sum_out` reads 0x0000. After reset is released, any lane whose load strobe stays high keeps contributing a data value of zero.
- R2: A lane's data register takes `px_in[i]` on a rising edge only when `ld_n[i]` is 0. When `ld_n[i]` is 1, the register keeps its previous value.
- R3: Each lane product is the signed product of its registered data (bit 9 is the sign) and its weight (bit 10 is the sign). Weights are sampled on every edge and have no load strobe.
- R4: With `fmt_int` = 1, `sum_out` equals bits [15:0] of the exact sum of the four products. Overflow wraps without saturation.
- R5: With `fmt_int` = 0, `sum_out` equals bits [24:9] of the exact sum sign-extended to 25 bits. This is the sum divided by 512 with truncation toward minus infinity. The top three output bits are always equal.
- R6: Data, weights and format sampled at one rising edge set `sum_out` after the second rising edge that follows, three edges in all. If every product register is zero, the next output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock for all registers |
| rst_n | input | 1 | Asynchronous active-low reset |
| px_in | input | 4x10 | Data lanes, lane i at bits [10i+9:10i], two's complement |
| ld_n | input | 4 | Active-low load strobe per data lane |
| coef_in | input | 4x11 | Weight per lane, lane i at bits [11i+10:11i], two's complement |
| fmt_int | input | 1 | 0 = fractional window, 1 = integer window |
| sum_out | output | 16 | Registered windowed sum |

## Verification
Two things can happen to a lane in the same cycle. Its data register can hold because its strobe is high, while the format select and the weights change for the data already in flight. The bench drives both at once with a pseudo-random stream of strobes, weights and format bits on every cycle. It keeps its own model of each lane's held data and checks every output three edges later against the mode that travelled with that vector. A directed sweep of signed corner operands in both modes comes first. A reset in mid-stream follows, after which lanes that never load must still contribute zero.

// File: rtl/qmf_pkg.sv
package qmf_pkg;

    // Output window interpretation carried down the pipeline
    typedef enum logic {
        FMT_FRAC = 1'b0,
        FMT_INT  = 1'b1
    } fmt_e;

endpackage

// File: rtl/qmf_tap_stage.sv
module qmf_tap_stage #(
    parameter int DW = 10,
    parameter int CW = 11,
    localparam int PW = DW + CW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_n,
    input  logic [DW-1:0] d_in,
    input  logic [CW-1:0] c_in,
    output logic [PW-1:0] prod_q
);

    logic [DW-1:0]        d_q;
    logic [CW-1:0]        c_q;
    logic signed [PW-1:0] d_ext;
    logic signed [PW-1:0] c_ext;
    logic signed [PW-1:0] prod_d;

    // Stage 1: gated data capture, free-running weight capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            d_q <= '0;
            c_q <= '0;
        end else begin
            if (!ld_n) d_q <= d_in;
            c_q <= c_in;
        end
    end

    always_comb begin
        d_ext  = PW'($signed(d_q));
        c_ext  = PW'($signed(c_q));
        prod_d = d_ext * c_ext;
    end

    // Stage 2: product register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prod_q <= '0;
        else        prod_q <= prod_d;
    end

    // R2: strobe high leaves the lane data untouched
    a_r2_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        ld_n |=> (d_q == $past(d_q)));

    // R3: nonzero operands give a product whose sign is the xor of theirs
    a_r3_product_sign: assert property (@(posedge clk) disable iff (!rst_n)
        ((d_q != '0) && (c_q != '0)) |=> (prod_q[PW-1] == $past(d_q[DW-1] ^ c_q[CW-1])));

endmodule

// File: rtl/qmf_sum_window.sv
module qmf_sum_window
    import qmf_pkg::*;
#(
    parameter int NTAP = 4,
    parameter int PW   = 21,
    parameter int OW   = 16,
    parameter int FRAC = 9,
    localparam int SW  = PW + $clog2(NTAP),
    localparam int EW  = (SW > FRAC + OW) ? SW : FRAC + OW
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NTAP-1:0][PW-1:0]  prods,
    input  fmt_e                     fmt,
    output logic [OW-1:0]            win_q
);

    logic signed [SW-1:0] acc;
    logic signed [EW-1:0] ext;
    logic [OW-1:0]        win_d;

    always_comb begin
        acc = '0;
        for (int i = 0; i < NTAP; i++) begin
            acc = acc + SW'($signed(prods[i]));
        end
        ext = EW'(acc);
        unique case (fmt)
            FMT_FRAC: win_d = ext[FRAC+OW-1:FRAC];
            FMT_INT:  win_d = ext[OW-1:0];
            default:  win_d = '0;
        endcase
    end

    // Stage 3: output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) win_q <= '0;
        else        win_q <= win_d;
    end

    // R1: a cycle spent in reset leaves the output at zero
    a_r1_reset_out: assert property (@(posedge clk)
        !rst_n |=> (win_q == '0));

    // R5: fractional window always carries redundant sign bits
    generate
        if (SW <= FRAC + OW - 2) begin : g_headroom
            a_r5_frac_headroom: assert property (@(posedge clk) disable iff (!rst_n)
                (fmt == FMT_FRAC) |=> ((win_q[OW-1:OW-3] == 3'b000) || (win_q[OW-1:OW-3] == 3'b111)));
        end
    endgenerate

endmodule

// File: rtl/quad_mac_filter.sv
module quad_mac_filter
    import qmf_pkg::*;
#(
    parameter int NTAP = 4,
    parameter int DW   = 10,
    parameter int CW   = 11,
    parameter int OW   = 16,
    parameter int FRAC = 9,
    localparam int PW  = DW + CW
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NTAP-1:0][DW-1:0] px_in,
    input  logic [NTAP-1:0]         ld_n,
    input  logic [NTAP-1:0][CW-1:0] coef_in,
    input  logic                    fmt_int,
    output logic [OW-1:0]           sum_out
);

    logic [NTAP-1:0][PW-1:0] prod_bus;
    fmt_e                    fmt_s1;
    fmt_e                    fmt_s2;

    generate
        for (genvar g = 0; g < NTAP; g++) begin : g_lane
            qmf_tap_stage #(
                .DW (DW),
                .CW (CW)
            ) u_lane (
                .clk    (clk),
                .rst_n  (rst_n),
                .ld_n   (ld_n[g]),
                .d_in   (px_in[g]),
                .c_in   (coef_in[g]),
                .prod_q (prod_bus[g])
            );
        end
    endgenerate

    // Format bit travels alongside the data it qualifies
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fmt_s1 <= FMT_FRAC;
            fmt_s2 <= FMT_FRAC;
        end else begin
            fmt_s1 <= fmt_e'(fmt_int);
            fmt_s2 <= fmt_s1;
        end
    end

    qmf_sum_window #(
        .NTAP (NTAP),
        .PW   (PW),
        .OW   (OW),
        .FRAC (FRAC)
    ) u_window (
        .clk   (clk),
        .rst_n (rst_n),
        .prods (prod_bus),
        .fmt   (fmt_s2),
        .win_q (sum_out)
    );

    // R6: an all-zero product stage produces a zero result one edge later
    a_r6_zero_flow: assert property (@(posedge clk) disable iff (!rst_n)
        (prod_bus == '0) |=> (sum_out == '0));

endmodule

// File: tb/quad_mac_filter_test.sv
module quad_mac_filter_test;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [3:0][9:0]  px = '0;
    logic [3:0]       ld_n = 4'hF;
    logic [3:0][10:0] cf = '0;
    logic             fmt = 1'b0;
    logic [15:0]      q;

    int          checks = 0;
    int          fails = 0;
    int          cyc = 0;
    int          md [4];
    logic [15:0] exq [4];
    logic        exf [4];
    logic        done = 1'b0;
    int unsigned lcg = 32'h1234_5678;

    always #5 clk = ~clk;

    quad_mac_filter uut (
        .clk     (clk),
        .rst_n   (rst_n),
        .px_in   (px),
        .ld_n    (ld_n),
        .coef_in (cf),
        .fmt_int (fmt),
        .sum_out (q)
    );

    function automatic int unsigned nxt();
        lcg = lcg * 32'd1664525 + 32'd1013904223;
        return lcg;
    endfunction

    task automatic check_val(input string tag, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s cycle %0d: got %h expected %h", tag, cyc, got, exp);
        end
    endtask

    // One vector per clock; result of vector k is checked at negedge k+3 (R6)
    task automatic step(input logic [3:0][9:0] dv, input logic [3:0] en,
                        input logic [3:0][10:0] cv, input logic f);
        int s;
        int t;
        @(negedge clk);
        if (cyc >= 3) begin
            if (exf[(cyc-3)%4]) check_val("R4 (R2 R3 R6)", q, exq[(cyc-3)%4]);
            else                check_val("R5 (R2 R3 R6)", q, exq[(cyc-3)%4]);
        end
        px = dv; ld_n = en; cf = cv; fmt = f;
        s = 0;
        for (int i = 0; i < 4; i++) begin
            if (!en[i]) md[i] = int'($signed(dv[i]));   // R2 model
            s += md[i] * int'($signed(cv[i]));          // R3 model
        end
        t = f ? s : (s >>> 9);
        exq[cyc%4] = t[15:0];
        exf[cyc%4] = f;
        cyc++;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check_val("R1", q, 16'h0000);
        @(negedge clk);
        check_val("R1", q, 16'h0000);
        rst_n = 1'b1;
        for (int i = 0; i < 4; i++) md[i] = 0;
        cyc = 0;
    endtask

    initial begin
        int dvals [8] = '{-512, -511, -1, 0, 1, 255, 511, -256};
        int cvals [8] = '{-1024, -1023, -1, 0, 1, 512, 1023, -513};
        logic [3:0][9:0]  dv;
        logic [3:0][10:0] cv;
        logic [3:0]       en;
        for (int i = 0; i < 4; i++) md[i] = 0;
        do_reset();

        // Corner sweep in both modes (R3 R4 R5)
        for (int f = 0; f < 2; f++) begin
            for (int a = 0; a < 8; a++) begin
                for (int b = 0; b < 8; b++) begin
                    for (int i = 0; i < 4; i++) begin
                        dv[i] = 10'(dvals[(a+i)%8]);
                        cv[i] = 11'(cvals[(b+3*i)%8]);
                    end
                    step(dv, 4'h0, cv, f[0]);
                end
            end
        end

        // Largest magnitude sum: 2^21 -> int 0x0000, frac 0x1000 (R4 R5)
        for (int i = 0; i < 4; i++) begin
            dv[i] = 10'h200;
            cv[i] = 11'h400;
        end
        step(dv, 4'h0, cv, 1'b1);
        step(dv, 4'h0, cv, 1'b0);

        // Random stream: strobes, weights and mode change together (R2 R6)
        for (int k = 0; k < 1500; k++) begin
            for (int i = 0; i < 4; i++) begin
                dv[i] = 10'(nxt() >> 8);
                cv[i] = 11'(nxt() >> 8);
            end
            en = 4'(nxt() >> 12);
            step(dv, en, cv, nxt() >> 20 & 1);
        end
        for (int k = 0; k < 3; k++) step(dv, 4'hF, cv, 1'b1);

        // Mid-stream reset; lanes that never load stay zero (R1 R2)
        do_reset();
        for (int i = 0; i < 4; i++) begin
            dv[i] = 10'h155;
            cv[i] = 11'h3FF;
        end
        for (int k = 0; k < 6; k++) step(dv, 4'hF, cv, k[0]);
        dv[2] = 10'h3F0;
        step(dv, 4'b1011, cv, 1'b1);
        for (int k = 0; k < 4; k++) step(dv, 4'hF, cv, 1'b1);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule